// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block turns thirty-two already-synchronized GPIO input lines into interrupt requests. Each line is set up through a small register bus to sense a level or an edge, with a chosen polarity. A separate both-edge control can also make the line fire on any transition, whatever its other settings say. Edge events are held in a per-pin latch until software writes a one to that pin's end-of-interrupt bit. Level events follow the live pin value.

Software reads two views of the pending events. The raw view shows every detected event on an enabled pin and ignores the mask. The status view hides masked pins. A single interrupt line is the registered OR of the status view.

The configuration registers use a half-word write-mask scheme. A 32-bit register is reached as a low half at its base offset and a high half at base+4. In each write, bits [31:16] act as per-bit write enables for the data in bits [15:0]. Bits whose enable is clear keep their value. The block has no state machine: all behaviour is per-pin combinational decode around one edge latch per pin.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, and every enable, type, polarity and both-edge bit is 0. Raw status and status read 0, and `irq_out` is 0.
- R2: Configuration registers sit at these base offsets: enable 0x10, mask 0x18, type 0x20, polarity 0x28, both-edge 0x30. The low half (pins 15..0) is at the base and the high half (pins 31..16) is at base+4. A write updates data bit i (i in 0..15) only when bit 16+i of the write data is 1. A read of a half returns its 16 bits in rdata[15:0], with rdata[31:16] zero. Reads of unmapped offsets return 0.
- R3: With type bit 0 and both-edge bit 0, the pin is level-sensed. Its raw bit equals the live pin when the polarity bit is 1, and the inverted pin when it is 0. The raw bit is not latched.
- R4: With type bit 1 and both-edge bit 0, the pin is edge-sensed. Polarity 1 latches on a 0-to-1 transition, and polarity 0 latches on a 1-to-0 transition. The latch is set on the clock edge that first sees the new pin value.
- R5: With both-edge bit 1, the pin latches on any transition, regardless of its type and polarity bits.
- R6: Writing 1 to an end-of-interrupt bit clears that pin's edge latch. The end-of-interrupt register is at 0x60 (pins 15..0) and 0x64 (pins 31..16), using the same write-mask scheme as R2. It has no effect on level-sensed pins.
- R7: If a new edge event and the end-of-interrupt write for that pin occur in the same cycle, the latch stays set.
- R8: Raw status (read at 0x58, all 32 bits) ignores the mask. Status (read at 0x50, all 32 bits) equals raw AND NOT mask.
- R9: `irq_out` equals the OR of all status bits, registered once: it changes one clock edge after status changes.
- R10: A pin whose enable bit is 0 shows 0 in raw status and holds no latched event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data: [31:16] write enables, [15:0] values |
| bus_rdata | output | 32 | Read data, registered one cycle after `bus_rd` |
| pin_in | input | 32 | Synchronized GPIO input levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench steps each of eight type/polarity/both-edge combinations across pins in both register halves. For each combination it checks the raw view after a rise, after an end-of-interrupt, and after a fall. A design that swapped polarity, dropped the both-edge override, or latched level events would show a wrong raw bit on one of these steps.

Further directed cases cover:
- an edge arriving in the same cycle as its clear, where a design that let the clear win would drop a real event;
- a masked pin that still appears in raw status but not in status or on `irq_out`;
- half-word writes with partial enables, where a design that ignored the enables would corrupt neighbouring bits.

The one-cycle registration of `irq_out` is sampled on both sides of the clock edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int NPINS  = 32;
    localparam int HALF   = NPINS / 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int NCFG   = 5;

    localparam logic [ADDR_W-1:0] OFS_EN   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TYPE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_POL  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_BOTH = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h50;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_HI   = 8'h04;

    typedef enum int {
        CFG_EN   = 0,
        CFG_MASK = 1,
        CFG_TYPE = 2,
        CFG_POL  = 3,
        CFG_BOTH = 4
    } cfg_idx_e;

    function automatic logic [ADDR_W-1:0] cfg_base(input int idx);
        unique case (idx)
            CFG_EN:   return OFS_EN;
            CFG_MASK: return OFS_MASK;
            CFG_TYPE: return OFS_TYPE;
            CFG_POL:  return OFS_POL;
            default:  return OFS_BOTH;
        endcase
    endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NPINS-1:0]  stat_i,
    input  logic [NPINS-1:0]  raw_i,
    output logic [NPINS-1:0]  en_o,
    output logic [NPINS-1:0]  mask_o,
    output logic [NPINS-1:0]  kind_o,
    output logic [NPINS-1:0]  pol_o,
    output logic [NPINS-1:0]  both_o,
    output logic [NPINS-1:0]  eoi_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [NCFG-1:0][NPINS-1:0] cfg_w;
    logic [HALF-1:0] wen;
    logic [HALF-1:0] wval;
    logic [DATA_W-1:0] rsel;

    assign wen  = wdata_i[DATA_W-1:HALF];
    assign wval = wdata_i[HALF-1:0];

    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        localparam logic [ADDR_W-1:0] BASE = cfg_base(g);
        localparam logic [NPINS-1:0] RST = (g == CFG_MASK) ? '1 : '0;
        logic [NPINS-1:0] q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST;
            end else if (wr_i && addr_i == BASE) begin
                q[HALF-1:0] <= (q[HALF-1:0] & ~wen) | (wval & wen);
            end else if (wr_i && addr_i == (BASE + OFS_HI)) begin
                q[NPINS-1:HALF] <= (q[NPINS-1:HALF] & ~wen) | (wval & wen);
            end
        end
        assign cfg_w[g] = q;

        // R2: a half-word write with no enable bits set leaves the register alone
        a_r2_no_enable_no_change: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_i && (addr_i == BASE || addr_i == BASE + OFS_HI) && wen == '0) |=> $stable(q));
    end

    assign en_o   = cfg_w[CFG_EN];
    assign mask_o = cfg_w[CFG_MASK];
    assign kind_o = cfg_w[CFG_TYPE];
    assign pol_o  = cfg_w[CFG_POL];
    assign both_o = cfg_w[CFG_BOTH];

    always_comb begin
        eoi_o = '0;
        if (wr_i && addr_i == OFS_EOI)
            eoi_o[HALF-1:0] = wval & wen;
        else if (wr_i && addr_i == (OFS_EOI + OFS_HI))
            eoi_o[NPINS-1:HALF] = wval & wen;
    end

    always_comb begin
        rsel = '0;
        for (int g = 0; g < NCFG; g++) begin
            if (addr_i == cfg_base(g))
                rsel = {{(DATA_W-HALF){1'b0}}, cfg_w[g][HALF-1:0]};
            else if (addr_i == (cfg_base(g) + OFS_HI))
                rsel = {{(DATA_W-HALF){1'b0}}, cfg_w[g][NPINS-1:HALF]};
        end
        if (addr_i == OFS_STAT)
            rsel = stat_i;
        else if (addr_i == OFS_RAW)
            rsel = raw_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_o <= '0;
        else if (rd_i)
            rdata_o <= rsel;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] en_i,
    input  logic [NPINS-1:0] kind_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] both_i,
    input  logic [NPINS-1:0] eoi_i,
    output logic [NPINS-1:0] raw_o
);
    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= '0;
        else
            prev_q <= pin_i;
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise, fall, hit, edge_mode, level_act, latch_q;

        assign rise      = pin_i[p] & ~prev_q[p];
        assign fall      = ~pin_i[p] & prev_q[p];
        assign hit       = both_i[p] ? (rise | fall) : (pol_i[p] ? rise : fall);
        assign edge_mode = kind_i[p] | both_i[p];
        assign level_act = pol_i[p] ? pin_i[p] : ~pin_i[p];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                latch_q <= 1'b0;
            else if (!en_i[p] || !edge_mode)
                latch_q <= 1'b0;
            else if (hit)
                latch_q <= 1'b1;
            else if (eoi_i[p])
                latch_q <= 1'b0;
        end

        assign raw_o[p] = en_i[p] & (edge_mode ? latch_q : level_act);

        // R7: a fresh edge on an enabled edge pin is held even when cleared in the same cycle
        a_r7_edge_beats_eoi: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[p] && edge_mode && hit) |=> latch_q);
        // R6: a clear with no new edge empties the latch
        a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (eoi_i[p] && !hit) |=> !latch_q);
        // R10: a disabled pin holds no event
        a_r10_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[p] |=> !latch_q);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq_out
);
    logic [NPINS-1:0] en, mask, kind, pol, both, eoi, raw, status;

    gpio_irq_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .rd_i    (bus_rd),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .stat_i  (status),
        .raw_i   (raw),
        .en_o    (en),
        .mask_o  (mask),
        .kind_o  (kind),
        .pol_o   (pol),
        .both_o  (both),
        .eoi_o   (eoi),
        .rdata_o (bus_rdata)
    );

    gpio_irq_detect u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .en_i   (en),
        .kind_i (kind),
        .pol_i  (pol),
        .both_i (both),
        .eoi_i  (eoi),
        .raw_o  (raw)
    );

    assign status = raw & ~mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq_out <= 1'b0;
        else
            irq_out <= |status;
    end

    // R9: the combined request follows pending status one edge later
    a_r9_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |=> irq_out);
    a_r9_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
        !(|status) |=> !irq_out);
    // R8: a fully masked bank never raises the request
    a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |=> !irq_out);
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic        irq_out;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    gpio_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic setbit(input logic [7:0] base, input int b, input bit v);
        logic [31:0] d;
        d = (32'h1 << (b % 16 + 16)) | (32'(v) << (b % 16));
        wr(base + ((b >= 16) ? 8'h04 : 8'h00), d);
    endtask

    task automatic eoi_all();
        wr(8'h60, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int pins[4] = '{0, 7, 16, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", {31'b0, irq_out}, 32'h0);
        rd(8'h18, d); check("R1 mask lo", d, 32'h0000_FFFF);
        rd(8'h1C, d); check("R1 mask hi", d, 32'h0000_FFFF);
        rd(8'h10, d); check("R1 enable lo", d, 32'h0);
        rd(8'h24, d); check("R1 type hi", d, 32'h0);
        rd(8'h2C, d); check("R1 polarity hi", d, 32'h0);
        rd(8'h34, d); check("R1 both hi", d, 32'h0);
        rd(8'h50, d); check("R1 status", d, 32'h0);
        rd(8'h58, d); check("R1 raw", d, 32'h0);

        // R2: write-mask scheme on the type register halves
        wr(8'h20, 32'h0000_FFFF); rd(8'h20, d); check("R2 no enables", d, 32'h0);
        wr(8'h20, 32'h00FF_00A5); rd(8'h20, d); check("R2 partial enable", d, 32'h0000_00A5);
        wr(8'h20, 32'h0001_0000); rd(8'h20, d); check("R2 clear bit0 only", d, 32'h0000_00A4);
        wr(8'h24, 32'hFFFF_1234); rd(8'h24, d); check("R2 high half", d, 32'h0000_1234);
        rd(8'h20, d); check("R2 low half untouched", d, 32'h0000_00A4);
        rd(8'h44, d); check("R2 unmapped reads zero", d, 32'h0);
        wr(8'h20, 32'hFFFF_0000); wr(8'h24, 32'hFFFF_0000);

        // Sweep: 8 sensing modes across pins in both halves (R3, R4, R5, R6, R10)
        foreach (pins[i]) begin
            for (int m = 0; m < 8; m++) begin
                int p;
                bit kind, pol, both, edge_mode;
                logic [31:0] bitp;
                p = pins[i];
                kind = m[0]; pol = m[1]; both = m[2];
                edge_mode = kind | both;
                bitp = 32'h1 << p;
                pin_in = '0;
                setbit(8'h20, p, kind);
                setbit(8'h28, p, pol);
                setbit(8'h30, p, both);
                setbit(8'h10, p, 1'b1);
                eoi_all();
                rd(8'h58, d);
                check($sformatf("R3/R4 idle pin%0d mode%0d", p, m), d,
                      (!edge_mode && !pol) ? bitp : 32'h0);
                @(negedge clk); pin_in[p] = 1'b1;
                repeat (2) @(negedge clk);
                rd(8'h58, d);
                check($sformatf("R4/R5 rise pin%0d mode%0d", p, m), d,
                      (edge_mode ? (both | pol) : pol) ? bitp : 32'h0);
                eoi_all();
                rd(8'h58, d);
                check($sformatf("R6 eoi pin%0d mode%0d", p, m), d,
                      (!edge_mode && pol) ? bitp : 32'h0);
                @(negedge clk); pin_in[p] = 1'b0;
                repeat (2) @(negedge clk);
                rd(8'h58, d);
                check($sformatf("R4/R5 fall pin%0d mode%0d", p, m), d,
                      (edge_mode ? (both | !pol) : !pol) ? bitp : 32'h0);
                setbit(8'h10, p, 1'b0);
                setbit(8'h20, p, 1'b0);
                setbit(8'h28, p, 1'b0);
                setbit(8'h30, p, 1'b0);
                rd(8'h58, d);
                check($sformatf("R10 disabled pin%0d mode%0d", p, m), d, 32'h0);
            end
        end

        // R10: disabled pin toggling leaves raw empty
        pin_in = 32'h0000_0400;
        repeat (2) @(negedge clk);
        pin_in = '0;
        rd(8'h58, d); check("R10 disabled toggle", d, 32'h0);

        // R7: edge in the same cycle as its clear keeps the latch (pin 20, rising)
        setbit(8'h20, 20, 1'b1); setbit(8'h28, 20, 1'b1); setbit(8'h10, 20, 1'b1);
        @(negedge clk); pin_in[20] = 1'b1;
        @(negedge clk); pin_in[20] = 1'b0;
        @(negedge clk);
        pin_in[20] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h64; bus_wdata = 32'h0010_0010;
        @(negedge clk); bus_wr = 1'b0;
        rd(8'h58, d); check("R7 edge wins over eoi", d, 32'h0010_0000);
        wr(8'h64, 32'h0010_0010);
        rd(8'h58, d); check("R6 lone eoi clears", d, 32'h0);
        pin_in[20] = 1'b0;
        setbit(8'h10, 20, 1'b0);

        // R6: eoi has no effect on a level pin (pin 3, active high)
        setbit(8'h28, 3, 1'b1); setbit(8'h10, 3, 1'b1);
        @(negedge clk); pin_in[3] = 1'b1;
        wr(8'h60, 32'h0008_0008);
        rd(8'h58, d); check("R6 eoi ignored on level", d, 32'h0000_0008);

        // R8/R9: masked level pin seen in raw, hidden from status and irq
        rd(8'h50, d); check("R8 masked status", d, 32'h0);
        check("R8 masked irq", {31'b0, irq_out}, 32'h0);
        setbit(8'h18, 3, 1'b0);
        rd(8'h50, d); check("R8 unmasked status", d, 32'h0000_0008);
        check("R9 irq high", {31'b0, irq_out}, 32'h1);
        @(negedge clk); pin_in[3] = 1'b0;
        #1 check("R9 irq still registered", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R9 irq drops one edge later", {31'b0, irq_out}, 32'h0);
        @(negedge clk); pin_in[3] = 1'b1;
        #1 check("R9 irq not yet up", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        check("R9 irq up one edge later", {31'b0, irq_out}, 32'h1);
        setbit(8'h18, 3, 1'b1);
        check("R9 irq held after mask write", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        check("R8 mask drops irq", {31'b0, irq_out}, 32'h0);
        rd(8'h58, d); check("R8 raw ignores mask", d, 32'h0000_0008);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule